// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two banks of divided clocks from one source clock. The source is picked from three clock inputs: two reference clocks and an oscillator clock. One select input chooses between the two references. A second select input chooses between the oscillator and the chosen reference. Each bank divides the source by an even ratio picked by its own 2-bit code. Bank A offers ratios of 2, 4, 6 and 8. Bank B offers ratios of 4, 6, 8 and 12. Each bank drives four identical copies of its divided clock.

A single active-high park input does two jobs. It clears every divider register, and it releases all eight outputs to high impedance. Park takes effect at once. Its release is synchronised to the source clock, so both banks restart from a common zero count and their first rising edges land on the same source edge. A new ratio code is taken up only at a bank's next rising edge. The period already under way therefore always finishes at its old length, and no short pulse appears.

Top module: `twin_bank_clkdiv`

## Requirements
- R1: Bank A divides the source by 2, 4, 6 or 8 for `a_ratio` codes 0, 1, 2 and 3.
- R2: Bank B divides the source by 4, 6, 8 or 12 for `b_ratio` codes 0, 1, 2 and 3.
- R3: Every output has a 50% duty cycle. For a ratio of N it stays high for N/2 source cycles and low for N/2 source cycles, and each period starts with its high phase.
- R4: All four outputs of a bank carry the same value at all times.
- R5: While `park` is high, all eight outputs are high impedance from the moment it rises, without waiting for a clock edge. The ratio codes have no visible effect while `park` is held.
- R6: After `park` falls, the outputs are driven low from the second source rising edge. Both banks then go high together on the third source rising edge.
- R7: When `osc_pick` is 0, the source is `ref0_clk` if `ref_pick` is 0 and `ref1_clk` if `ref_pick` is 1.
- R8: When `osc_pick` is 1, the source is `osc_clk`, whatever the value of `ref_pick`.
- R9: A bank samples its ratio code only at the rising edge that starts each output period. A code change in mid-period leaves the current period at its old high and low lengths, and the new ratio applies from the next period on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref0_clk | input | 1 | First reference clock |
| ref1_clk | input | 1 | Second reference clock |
| osc_clk | input | 1 | Oscillator clock |
| ref_pick | input | 1 | Reference choice: 0 selects ref0_clk, 1 selects ref1_clk |
| osc_pick | input | 1 | 1 takes the oscillator as source; 0 takes the chosen reference |
| park | input | 1 | Active high: clears the dividers and releases all outputs to high impedance |
| a_ratio | input | 2 | Bank A ratio code |
| b_ratio | input | 2 | Bank B ratio code |
| a_clk_q | output | COPIES | Bank A clock copies (tristate) |
| b_clk_q | output | COPIES | Bank B clock copies (tristate) |

## Verification
The bench measures output periods and high times in absolute time. It does this for every ratio code of both banks, under each of the three source choices, mixing random combinations with a directed sweep. Because the three clocks have distinct periods, a wrong source choice shows up as a different period, while a wrong ratio or wrong duty shows up as a mismatch against the expected half-period. The park tests pull the output nets up. A driven low level then separates an enabled output from a released one, which lets the bench time the release edge by edge. Ratio changes are applied in the middle of a high phase, so the bench can tell a change taken at the period boundary apart from one that cuts a phase short.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Width of a half-period count (largest half period is 6 source cycles).
  parameter int unsigned HALF_W = 3;

  typedef logic [HALF_W-1:0]         half_t;
  typedef logic [1:0]                ratio_code_t;
  typedef logic [3:0][HALF_W-1:0]    half_tab_t;

  // Half-period lengths indexed by ratio code (element 0 = code 0).
  localparam half_tab_t BANK_A_HALVES = {half_t'(4), half_t'(3), half_t'(2), half_t'(1)};
  localparam half_tab_t BANK_B_HALVES = {half_t'(6), half_t'(4), half_t'(3), half_t'(2)};

endpackage

// File: rtl/src_select.sv
`timescale 1ns/1ps
module src_select (
  input  logic ref0_clk,
  input  logic ref1_clk,
  input  logic osc_clk,
  input  logic ref_pick,
  input  logic osc_pick,
  output logic src_clk
);

  logic ref_clk;

  always_comb begin
    ref_clk = ref_pick ? ref1_clk : ref0_clk;
    src_clk = osc_pick ? osc_clk : ref_clk;
  end

endmodule

// File: rtl/park_sync.sv
`timescale 1ns/1ps
module park_sync #(
  parameter int STAGES = 2  // must be at least 2
) (
  input  logic clk,
  input  logic park,
  output logic run
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // Next state: shift a one towards the output.
  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  // Asserted at once by park, released through the stage chain.
  always_ff @(posedge clk or posedge park) begin
    if (park) stage_q <= '0;
    else      stage_q <= stage_d;
  end

  assign run = stage_q[STAGES-1];

endmodule

// File: rtl/bank_divider.sv
`timescale 1ns/1ps
module bank_divider
  import clkdiv_pkg::*;
#(
  parameter half_tab_t HALF_TAB = BANK_A_HALVES
) (
  input  logic        clk,
  input  logic        run,
  input  ratio_code_t sel,
  output logic        div_q,
  output logic        started
);

  half_t cnt_q,  cnt_d;
  half_t half_q, half_d;
  logic  lvl_q,  lvl_d;
  logic  primed_q, primed_d;
  logic  wrap;
  logic  tick_en;

  assign tick_en = 1'b1;  // the divider advances on every source edge

  always_comb begin
    cnt_d    = cnt_q;
    half_d   = half_q;
    lvl_d    = lvl_q;
    primed_d = primed_q;
    wrap     = (cnt_q == half_t'(half_q - 1'b1));
    if (tick_en) begin
      if (!primed_q) begin
        // first edge after release: open a period, take the ratio
        primed_d = 1'b1;
        lvl_d    = 1'b1;
        cnt_d    = '0;
        half_d   = HALF_TAB[sel];
      end else if (wrap) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
        if (!lvl_q) half_d = HALF_TAB[sel];  // period boundary only
      end else begin
        cnt_d = half_t'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      cnt_q    <= '0;
      half_q   <= HALF_TAB[0];
      lvl_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      half_q   <= half_d;
      lvl_q    <= lvl_d;
      primed_q <= primed_d;
    end
  end

  assign div_q   = lvl_q;
  assign started = primed_q;

  // R3
  phase_len_chk: assert property (@(posedge clk) disable iff (!run)
    primed_q |-> (cnt_q < half_q));

  // R3
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!run)
    $rose(lvl_q) |-> (cnt_q == '0));

  // R3
  toggle_on_wrap_chk: assert property (@(posedge clk) disable iff (!run)
    (primed_q && $past(primed_q) && (lvl_q != $past(lvl_q)))
      |-> ($past(cnt_q) == $past(half_q) - 1));

  // R9
  ratio_boundary_chk: assert property (@(posedge clk) disable iff (!run)
    (primed_q && !$stable(half_q)) |-> $rose(lvl_q));

endmodule

// File: rtl/twin_bank_clkdiv.sv
`timescale 1ns/1ps
module twin_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int COPIES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ref0_clk,
  input  logic              ref1_clk,
  input  logic              osc_clk,
  input  logic              ref_pick,
  input  logic              osc_pick,
  input  logic              park,
  input  logic [1:0]        a_ratio,
  input  logic [1:0]        b_ratio,
  output logic [COPIES-1:0] a_clk_q,
  output logic [COPIES-1:0] b_clk_q
);

  logic src_clk;
  logic run;
  logic out_en;
  logic a_div, b_div;
  logic a_started, b_started;

  src_select u_src (
    .ref0_clk (ref0_clk),
    .ref1_clk (ref1_clk),
    .osc_clk  (osc_clk),
    .ref_pick (ref_pick),
    .osc_pick (osc_pick),
    .src_clk  (src_clk)
  );

  park_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (src_clk),
    .park (park),
    .run  (run)
  );

  assign out_en = run;

  bank_divider #(.HALF_TAB(BANK_A_HALVES)) u_bank_a (
    .clk     (src_clk),
    .run     (run),
    .sel     (a_ratio),
    .div_q   (a_div),
    .started (a_started)
  );

  bank_divider #(.HALF_TAB(BANK_B_HALVES)) u_bank_b (
    .clk     (src_clk),
    .run     (run),
    .sel     (b_ratio),
    .div_q   (b_div),
    .started (b_started)
  );

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign a_clk_q[i] = out_en ? a_div : 1'bz;
    assign b_clk_q[i] = out_en ? b_div : 1'bz;
  end

  // R5
  always @(posedge src_clk) begin
    if (park) begin
      hiz_on_park_chk: assert (!out_en);
    end
  end

  // R6
  start_together_chk: assert property (@(posedge src_clk) disable iff (!run)
    a_started == b_started);

endmodule

// File: tb/twin_bank_clkdiv_test.sv
`timescale 1ns/1ps
module twin_bank_clkdiv_test;

  localparam int CLK_PERIOD  = 10;   // ref0 period
  localparam int REF1_PERIOD = 16;
  localparam int OSC_PERIOD  = 4;

  logic ref0, ref1, osc;
  logic ref_pick, osc_pick, park;
  logic [1:0] a_ratio, b_ratio;
  wire  [3:0] qa, qb;
  logic probe_b;
  wire  probe = probe_b ? qb[0] : qa[0];

  int chk_cnt;
  int pass_cnt;
  bit finished;

  for (genvar i = 0; i < 4; i++) begin : g_pu
    pullup pu_a (qa[i]);
    pullup pu_b (qb[i]);
  end

  twin_bank_clkdiv uut (
    .ref0_clk (ref0),
    .ref1_clk (ref1),
    .osc_clk  (osc),
    .ref_pick (ref_pick),
    .osc_pick (osc_pick),
    .park     (park),
    .a_ratio  (a_ratio),
    .b_ratio  (b_ratio),
    .a_clk_q  (qa),
    .b_clk_q  (qb)
  );

  initial ref0 = 1'b0;
  always #(CLK_PERIOD/2) ref0 = ~ref0;
  initial ref1 = 1'b0;
  always #(REF1_PERIOD/2) ref1 = ~ref1;
  initial osc = 1'b0;
  always #(OSC_PERIOD/2) osc = ~osc;

  function automatic int half_a(input int code);
    return code + 1;
  endfunction

  function automatic int half_b(input int code);
    case (code)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int src_period(input bit o, input bit r);
    if (o) return OSC_PERIOD;
    return r ? REF1_PERIOD : CLK_PERIOD;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    chk_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic src_edge();
    if (osc_pick) @(posedge osc);
    else if (ref_pick) @(posedge ref1);
    else @(posedge ref0);
  endtask

  task automatic restart(input bit o, input bit r, input logic [1:0] a, input logic [1:0] b);
    #1 park = 1'b1;
    #1;
    osc_pick = o; ref_pick = r; a_ratio = a; b_ratio = b;
    #40;
    src_edge();
    #1 park = 1'b0;
  endtask

  task automatic measure(input bit bank, output int hi, output int per);
    int t0, t1, t2;
    probe_b = bank;
    #0;
    @(posedge probe); t0 = int'($time);
    @(negedge probe); t1 = int'($time);
    @(posedge probe); t2 = int'($time);
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic check_banks(input string req_a, input string req_b);
    int hi, per, exp_per;
    exp_per = 2 * half_a(int'(a_ratio)) * src_period(osc_pick, ref_pick);
    measure(1'b0, hi, per);
    check(per == exp_per, req_a, "bank A period", per, exp_per);
    check(hi * 2 == per, "R3", "bank A high time", hi, per / 2);
    exp_per = 2 * half_b(int'(b_ratio)) * src_period(osc_pick, ref_pick);
    measure(1'b1, hi, per);
    check(per == exp_per, req_b, "bank B period", per, exp_per);
    check(hi * 2 == per, "R3", "bank B high time", hi, per / 2);
  endtask

  task automatic check_copies();
    for (int k = 0; k < 6; k++) begin
      #3;
      check(qa === {4{qa[0]}}, "R4", "bank A copies differ", int'(qa), int'({4{qa[0]}}));
      check(qb === {4{qb[0]}}, "R4", "bank B copies differ", int'(qb), int'({4{qb[0]}}));
    end
  endtask

  initial begin
    int hi, per, tr, tf, tr2, seed;
    chk_cnt = 0; pass_cnt = 0; finished = 1'b0;
    probe_b = 1'b0;
    park = 1'b1; osc_pick = 1'b1; ref_pick = 1'b0;
    a_ratio = 2'd0; b_ratio = 2'd0;
    seed = $urandom(32'd5171);

    // R5: reset state, all outputs released (pulled up)
    #30;
    check(qa === 4'hF, "R5", "bank A not released in park", int'(qa), 15);
    check(qb === 4'hF, "R5", "bank B not released in park", int'(qb), 15);

    // R6: release sequence on the oscillator
    src_edge(); #1 park = 1'b0;
    src_edge(); #1;
    check(qa === 4'hF, "R6", "bank A driven after first edge", int'(qa), 15);
    src_edge(); #1;
    check(qa === 4'h0, "R6", "bank A low after second edge", int'(qa), 0);
    check(qb === 4'h0, "R6", "bank B low after second edge", int'(qb), 0);
    src_edge(); #1;
    check(qa === 4'hF && qb === 4'hF, "R6", "banks not high together on third edge",
          int'({qa, qb}), 255);
    src_edge(); #1;
    check(qa === 4'h0, "R6", "bank A code 0 low on fourth edge", int'(qa), 0);
    check(qb === 4'hF, "R6", "bank B code 0 high on fourth edge", int'(qb), 15);

    // R1 R2: every code on the oscillator
    for (int c = 0; c < 4; c++) begin
      restart(1'b1, 1'b0, 2'(c), 2'(c));
      check_banks("R1", "R2");
    end
    check_copies();

    // R7: reference choice
    restart(1'b0, 1'b0, 2'd1, 2'd1);
    check_banks("R7", "R7");
    restart(1'b0, 1'b1, 2'd2, 2'd3);
    check_banks("R7", "R7");
    check_copies();

    // R8: oscillator overrides reference choice
    restart(1'b1, 1'b1, 2'd3, 2'd2);
    check_banks("R8", "R8");

    // R5: park takes effect at once and codes are ignored while held
    @(negedge qa[0]); #1 park = 1'b1;
    #1;
    check(qa === 4'hF && qb === 4'hF, "R5", "outputs not released at once", int'({qa, qb}), 255);
    for (int k = 0; k < 5; k++) begin
      a_ratio = 2'($urandom_range(3, 0));
      b_ratio = 2'($urandom_range(3, 0));
      #7;
      check(qa === 4'hF && qb === 4'hF, "R5", "outputs moved while parked", int'({qa, qb}), 255);
    end

    // R9: ratio change in mid high phase
    restart(1'b1, 1'b0, 2'd0, 2'd3);
    measure(1'b0, hi, per);
    @(posedge qa[0]); tr = int'($time);
    #1 a_ratio = 2'd3;
    @(negedge qa[0]); tf = int'($time);
    @(posedge qa[0]); tr2 = int'($time);
    check(tf - tr == OSC_PERIOD, "R9", "bank A old high phase", tf - tr, OSC_PERIOD);
    check(tr2 - tr == 2 * OSC_PERIOD, "R9", "bank A old period", tr2 - tr, 2 * OSC_PERIOD);
    for (int k = 0; k < 3; k++) begin
      measure(1'b0, hi, per);
      check(per == 8 * OSC_PERIOD, "R9", "bank A new period", per, 8 * OSC_PERIOD);
      check(hi == 4 * OSC_PERIOD, "R9", "bank A new high", hi, 4 * OSC_PERIOD);
    end
    @(posedge qb[0]); tr = int'($time);
    #1 b_ratio = 2'd0;
    @(negedge qb[0]); tf = int'($time);
    @(posedge qb[0]); tr2 = int'($time);
    check(tf - tr == 6 * OSC_PERIOD, "R9", "bank B old high phase", tf - tr, 6 * OSC_PERIOD);
    check(tr2 - tr == 12 * OSC_PERIOD, "R9", "bank B old period", tr2 - tr, 12 * OSC_PERIOD);
    measure(1'b1, hi, per);
    check(per == 4 * OSC_PERIOD, "R9", "bank B new period", per, 4 * OSC_PERIOD);

    // Random mix of sources and codes (R1 R2 R7 R8)
    for (int it = 0; it < 14; it++) begin
      int s;
      s = int'($urandom_range(2, 0));
      restart(s == 2, s == 1, 2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)));
      if (s == 2) check_banks("R8", "R8");
      else        check_banks("R1", "R2");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      chk_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
    end
  end

endmodule